// File: doc/BRIEF.md
# Three-State Phase-Frequency Detector with Out-of-Lock Flag

This block compares two single-cycle strobes in a fast system-clock domain. One strobe marks each edge of the divided reference. The other marks each edge of the divided oscillator. From their order it produces a loop-error drive with three states: a drive-enable plus a drive-level, where a disabled drive stands for high impedance. When the reference edge arrives first, the oscillator is behind, so the block drives high. When the oscillator edge arrives first, the oscillator is ahead, so the block drives low. When both edges arrive together, the output is released.

An out-of-lock flag watches the width of each error pulse against a programmable limit. The flag rises as soon as a pulse runs too long. It falls again only after a number of consecutive reference intervals with no such event. A loop-enable input puts the loop in standby: the drive is released and the detector state is cleared.

Top module: `loop_pfd`

## Requirements
- R1: A reference strobe with no drive active sets the drive to enabled with level 1 from the next cycle. The drive stays that way until an oscillator strobe arrives.
- R2: An oscillator strobe with no drive active sets the drive to enabled with level 0 from the next cycle. The drive stays that way until a reference strobe arrives.
- R3: The opposite strobe of an active drive releases it (drv_en = 0) in the next cycle. Reference and oscillator strobes in the same cycle with no drive active leave the drive released.
- R4: While loop_en is 0, the drive is released from the next cycle and strobes have no effect. On re-enable the drive starts released.
- R5: After reset, drv_en = 0, drv_level = 0 and unlocked = 1.
- R6: If the drive stays enabled for more than width_limit consecutive cycles, unlocked is 1 in the cycle after that limit is exceeded. A pulse of at most width_limit cycles does not set it.
- R7: A comparison interval runs from one reference strobe to the next. unlocked falls to 0 in the cycle after the CLEAN_CYCLES-th consecutive reference strobe that closes a violation-free interval. A violation restarts that count, and the interval that held the violation does not count.
- R8: Dropping loop_en sets unlocked to 1 in the next cycle and restarts the clean-interval count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loop_en | input | 1 | Loop enable; 0 is standby |
| ref_strobe | input | 1 | One-cycle pulse per divided reference edge |
| vco_strobe | input | 1 | One-cycle pulse per divided oscillator edge |
| width_limit | input | LIM_W | Longest error pulse, in cycles, that still counts as locked |
| drv_en | output | 1 | Error drive enabled (0 = high impedance) |
| drv_level | output | 1 | Drive level while enabled: 1 pumps up, 0 pumps down |
| unlocked | output | 1 | 1 when the loop is out of lock |

## Verification
The bench targets the following corner cases:
- **Coincident strobes.** A detector that lets one flag win would emit a spurious one-cycle pulse here.
- **Strobes during standby.** A design that keeps its flags would resume driving on re-enable.
- **Pulse-width boundary.** Pulses of exactly width_limit and width_limit+1 cycles are applied. An off-by-one comparison either flags a legal pulse or misses a long one.
- **Relock after a violation and after standby.** Here the interval holding the violation must not count toward relock, and the clean count must restart. A counter that is not cleared would drop the flag early.

// File: rtl/pfd_pkg.sv
// Package: shared types for the phase-frequency detector.
// Assumes nothing beyond a two-flag detector state.
package pfd_pkg;

    // Drive pair towards the charge pump: en = 0 means high impedance.
    typedef struct packed {
        logic en;
        logic level;
    } drive_t;

    // Map detector flags to the three-state drive.
    function automatic drive_t drive_of(input logic up, input logic dn);
        drive_t d;
        d.en    = up | dn;
        d.level = up;
        return d;
    endfunction

endpackage

// File: rtl/pfd_flags.sv
// Two-flag phase-frequency detector core.
// The reference strobe sets up_q and the oscillator strobe sets dn_q.
// When both would be set, both clear. Standby clears both.
// Assumes strobes are single-cycle and synchronous to clk.
module pfd_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_en,
    input  logic ref_strobe,
    input  logic vco_strobe,
    output logic up_q,
    output logic dn_q
);
    logic up_nx, dn_nx;

    // Next-state: accumulate strobes, reset both once both are set.
    always_comb begin
        up_nx = up_q | ref_strobe;
        dn_nx = dn_q | vco_strobe;
        if ((up_nx && dn_nx) || !loop_en) begin
            up_nx = 1'b0;
            dn_nx = 1'b0;
        end
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_nx;
            dn_q <= dn_nx;
        end
    end
endmodule

// File: rtl/pfd_width_mon.sv
// Error-pulse width monitor.
// Counts consecutive cycles with the drive enabled and raises viol
// while the count has already reached the programmed limit.
// Assumes the limit is stable during a pulse; the counter saturates.
module pfd_width_mon #(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loop_en,
    input  logic             drv_active,
    input  logic [LIM_W-1:0] width_limit,
    output logic             viol
);
    localparam logic [LIM_W-1:0] CNT_MAX = '1;

    logic [LIM_W-1:0] wcnt;

    // Violation: pulse still active after width_limit cycles already counted.
    assign viol = drv_active && (wcnt >= width_limit);

    // Saturating width counter, cleared between pulses and in standby.
    always_ff @(posedge clk) begin
        if (!rst_n || !loop_en || !drv_active) begin
            wcnt <= '0;
        end else if (wcnt != CNT_MAX) begin
            wcnt <= wcnt + 1'b1;
        end
    end
endmodule

// File: rtl/pfd_lock_fsm.sv
// Out-of-lock flag state.
// Sets unlocked on a width violation or in standby. Clears it after
// CLEAN_CYCLES consecutive violation-free reference intervals.
// Assumes CLEAN_CYCLES >= 1.
module pfd_lock_fsm #(
    parameter int CLEAN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_en,
    input  logic ref_strobe,
    input  logic viol,
    output logic unlocked
);
    localparam int CNT_W = (CLEAN_CYCLES > 1) ? $clog2(CLEAN_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLEAN_CYCLES - 1);

    logic [CNT_W-1:0] clean_cnt;
    logic             dirty;

    // Interval bookkeeping and lock flag update.
    always_ff @(posedge clk) begin
        if (!rst_n || !loop_en) begin
            unlocked  <= 1'b1;
            clean_cnt <= '0;
            dirty     <= 1'b0;
        end else if (viol) begin
            unlocked  <= 1'b1;
            clean_cnt <= '0;
            dirty     <= 1'b1;
        end else if (ref_strobe) begin
            if (dirty) begin
                dirty     <= 1'b0;
                clean_cnt <= '0;
            end else if (clean_cnt == LAST) begin
                unlocked  <= 1'b0;
            end else begin
                clean_cnt <= clean_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/loop_pfd.sv
// Top: three-state phase-frequency detector with an out-of-lock flag.
// Combines the flag core, the pulse-width monitor and the lock state.
// Assumes all inputs are synchronous to clk.
module loop_pfd
    import pfd_pkg::*;
#(
    parameter int LIM_W        = 8,
    parameter int CLEAN_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loop_en,
    input  logic             ref_strobe,
    input  logic             vco_strobe,
    input  logic [LIM_W-1:0] width_limit,
    output logic             drv_en,
    output logic             drv_level,
    output logic             unlocked
);
    logic   up_w, dn_w, viol_w;
    drive_t drv;

    pfd_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .loop_en    (loop_en),
        .ref_strobe (ref_strobe),
        .vco_strobe (vco_strobe),
        .up_q       (up_w),
        .dn_q       (dn_w)
    );

    // Three-state drive derived from the flags.
    assign drv       = drive_of(up_w, dn_w);
    assign drv_en    = drv.en;
    assign drv_level = drv.level;

    pfd_width_mon #(.LIM_W(LIM_W)) u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .loop_en     (loop_en),
        .drv_active  (drv.en),
        .width_limit (width_limit),
        .viol        (viol_w)
    );

    pfd_lock_fsm #(.CLEAN_CYCLES(CLEAN_CYCLES)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .loop_en    (loop_en),
        .ref_strobe (ref_strobe),
        .viol       (viol_w),
        .unlocked   (unlocked)
    );
endmodule

// File: rtl/loop_pfd_chk.sv
// Checker bound to loop_pfd: temporal properties of drive and lock flag.
module loop_pfd_chk (
    input logic clk,
    input logic rst_n,
    input logic loop_en,
    input logic ref_strobe,
    input logic vco_strobe,
    input logic drv_en,
    input logic drv_level,
    input logic unlocked,
    input logic viol
);
    p_up_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && ref_strobe && !vco_strobe && !drv_en) |=> (drv_en && drv_level));

    p_dn_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && vco_strobe && !ref_strobe && !drv_en) |=> (drv_en && !drv_level));

    p_release_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && drv_level && vco_strobe) |=> !drv_en);

    p_coincide_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_strobe && vco_strobe && !drv_en) |=> !drv_en);

    p_standby_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> !drv_en);

    p_unlock_viol_r6: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> unlocked);

    p_relock_on_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unlocked) |-> $past(ref_strobe));

    p_standby_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> unlocked);
endmodule

bind loop_pfd loop_pfd_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .loop_en    (loop_en),
    .ref_strobe (ref_strobe),
    .vco_strobe (vco_strobe),
    .drv_en     (drv_en),
    .drv_level  (drv_level),
    .unlocked   (unlocked),
    .viol       (viol_w)
);

// File: tb/loop_pfd_bench.sv
// Directed bench for loop_pfd: one task per scenario.
module loop_pfd_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loop_en = 1'b0;
    logic       ref_strobe = 1'b0;
    logic       vco_strobe = 1'b0;
    logic [7:0] width_limit = 8'd200;
    logic       drv_en, drv_level, unlocked;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    loop_pfd u_loop_pfd (
        .clk         (clk),
        .rst_n       (rst_n),
        .loop_en     (loop_en),
        .ref_strobe  (ref_strobe),
        .vco_strobe  (vco_strobe),
        .width_limit (width_limit),
        .drv_en      (drv_en),
        .drv_level   (drv_level),
        .unlocked    (unlocked)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // All stimulus tasks start and end at a falling edge.
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_ref();
        ref_strobe = 1'b1; @(negedge clk); ref_strobe = 1'b0;
    endtask

    task automatic send_vco();
        vco_strobe = 1'b1; @(negedge clk); vco_strobe = 1'b0;
    endtask

    task automatic send_both();
        ref_strobe = 1'b1; vco_strobe = 1'b1; @(negedge clk);
        ref_strobe = 1'b0; vco_strobe = 1'b0; idle(3);
    endtask

    task automatic t_reset_r5();
        check("R5", "drv_en", drv_en, 1'b0);
        check("R5", "drv_level", drv_level, 1'b0);
        check("R5", "unlocked", unlocked, 1'b1);
    endtask

    task automatic t_ref_first_r1();
        send_ref();
        check("R1", "drv_en", drv_en, 1'b1);
        check("R1", "drv_level", drv_level, 1'b1);
        idle(3);
        check("R1", "drv_en held", drv_en, 1'b1);
        send_vco();
        check("R3", "released after vco", drv_en, 1'b0);
    endtask

    task automatic t_vco_first_r2();
        send_vco();
        check("R2", "drv_en", drv_en, 1'b1);
        check("R2", "drv_level", drv_level, 1'b0);
        idle(2);
        check("R2", "drv_en held", drv_en, 1'b1);
        send_ref();
        check("R3", "released after ref", drv_en, 1'b0);
    endtask

    task automatic t_coincide_r3();
        ref_strobe = 1'b1; vco_strobe = 1'b1; @(negedge clk);
        ref_strobe = 1'b0; vco_strobe = 1'b0;
        check("R3", "coincident drv_en", drv_en, 1'b0);
        idle(1);
        check("R3", "coincident later", drv_en, 1'b0);
    endtask

    task automatic t_standby_r4();
        send_ref();
        check("R4", "pulse before standby", drv_en, 1'b1);
        loop_en = 1'b0; @(negedge clk);
        check("R4", "standby releases", drv_en, 1'b0);
        check("R8", "standby unlocked", unlocked, 1'b1);
        send_ref();
        check("R4", "ref ignored", drv_en, 1'b0);
        send_vco();
        check("R4", "vco ignored", drv_en, 1'b0);
        loop_en = 1'b1; @(negedge clk);
        check("R4", "re-enable released", drv_en, 1'b0);
    endtask

    task automatic t_acquire_r7();
        width_limit = 8'd4;
        repeat (3) send_both();
        check("R7", "after 3 clean", unlocked, 1'b1);
        send_both();
        check("R7", "after 4 clean", unlocked, 1'b0);
    endtask

    task automatic t_width_r6();
        send_ref(); idle(3); send_vco();       // 4-cycle pulse
        check("R6", "width at limit", unlocked, 1'b0);
        idle(2);
        send_ref(); idle(4);
        check("R6", "before overrun", unlocked, 1'b0);
        send_vco();                            // 5-cycle pulse
        check("R6", "width over limit", unlocked, 1'b1);
        idle(2);
    endtask

    task automatic t_relock_r7();
        repeat (4) send_both();                // first closes the dirty interval
        check("R7", "dirty interval not counted", unlocked, 1'b1);
        send_both();
        check("R7", "relock", unlocked, 1'b0);
    endtask

    task automatic t_standby_restart_r8();
        loop_en = 1'b0; @(negedge clk);
        check("R8", "standby sets unlocked", unlocked, 1'b1);
        loop_en = 1'b1; idle(1);
        send_both();
        check("R8", "count restarted", unlocked, 1'b1);
        repeat (3) send_both();
        check("R8", "relock after standby", unlocked, 1'b0);
    endtask

    task automatic t_short_limit_r6();
        width_limit = 8'd2;
        send_ref(); idle(1); send_vco();       // 2-cycle pulse
        check("R6", "limit 2 width 2", unlocked, 1'b0);
        send_vco(); idle(2); send_ref();       // 3-cycle pulse
        check("R6", "limit 2 width 3", unlocked, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset_r5();
        loop_en = 1'b1;
        idle(1);
        t_ref_first_r1();
        t_vco_first_r2();
        t_coincide_r3();
        t_standby_r4();
        t_acquire_r7();
        t_width_r6();
        t_relock_r7();
        t_standby_restart_r8();
        t_short_limit_r6();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule